// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This engine walks a chain of four-word transmit descriptors held in system memory. The words are read as: status, control, buffer address, next-descriptor address. Every descriptor whose hand-off bit is set holds a buffer fragment. The engine reads that fragment and gathers it into an internal frame store. Once the fragment that closes a frame has been gathered, it plays the whole frame out as bytes on a valid/ready stream. It then writes each consumed descriptor's status back with the hand-off bit cleared and follows the next pointer.

Software loads a base pointer while the engine is idle. It then pulses a start input with the enable input held high. The engine keeps consuming descriptors until it meets one it does not own. It parks on that descriptor, and the current-descriptor output keeps showing its address, until start is pulsed again. Memory is reached through a single-outstanding request/grant port. Read data returns on the cycle after the grant.

Top module: `txd_chain_dma`

## Requirements
- R1: While reset is applied, `tx_valid` and `mem_req` are low and `cur_desc` is zero.
- R2: A `cfg_load` pulse while idle makes `cur_desc` equal `cfg_base` on the next cycle. If it coincides with start, the load takes priority and the start is dropped.
- R3: After start, the engine reads the descriptor words at byte addresses `cur_desc`+0, +4, +8 and +12. These hold status, control, buffer address and next pointer, in that order.
- R4: If status bit 31 (hand-off) is clear, the engine stops after that single status read. `cur_desc` keeps that address and that status word is left as it was. No further memory request is made until start is pulsed again.
- R5: A start pulse while `dma_en` is low is ignored: no memory request follows and `cur_desc` is unchanged.
- R6: The low CNT_W bits of the control word give the fragment length in bytes. The buffer is read as word-aligned 32-bit words. Its bytes leave in order, little-endian within a word (bits 7:0 first).
- R7: Control bit 30 marks the fragment that closes a frame. Fragments from consecutive descriptors are joined into one frame, and `tx_last` is high only on the final byte of the closing fragment.
- R8: A frame's first byte is offered only after every descriptor and buffer word of that frame has been read from memory.
- R9: Each consumed descriptor gets a status write at its own address. The value is the fetched status with bit 31 cleared. A non-closing descriptor is written as soon as its buffer has been read. A closing descriptor is written only after the frame's last byte has been accepted.
- R10: After a writeback, the engine continues at the next-pointer address, and `cur_desc` shows it. A chain whose last next pointer returns to its head is followed around.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R12: While `mem_req` is high and `mem_gnt` is low, the request, its address and its direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Engine enable level |
| start | input | 1 | Pulse: resume polling at the current descriptor |
| cfg_load | input | 1 | Pulse: load the descriptor pointer (idle only) |
| cfg_base | input | AW | Head descriptor byte address |
| cur_desc | output | AW | Current descriptor byte address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid (cycle after grant) |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream sink ready |

## Verification
The bench builds a looped chain in which one frame spans several fragments, and it makes the grant and ready inputs stall periodically. A design that streamed too early would show up two ways: it would offer the first byte before the closing fragment's words were read, or it would write a closing descriptor's status before the last byte left. A design with the wrong byte lane order or the wrong final-word length would send wrong bytes, or would raise `tx_last` on the wrong byte. The bench also parks the engine on an unowned descriptor, then hands that descriptor over and restarts. A design that kept polling, skipped the parked descriptor or ignored the enable level would issue extra reads or finish on the wrong `cur_desc`.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 30;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DWAIT, S_BREQ, S_BWAIT, S_GO, S_SEND, S_WB
  } dma_st_t;

  typedef enum logic [1:0] {
    D_IDLE, D_LD, D_CAP, D_OUT
  } drn_st_t;
endpackage

// File: rtl/txd_frame_buf.sv
module txd_frame_buf #(
  parameter int WORDS = 16,
  localparam int PW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    wr_nb,
  output logic [PW:0]   wr_cnt,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [1:0]    rd_nb
);
  logic [33:0] store [WORDS];
  logic [PW:0] wptr;

  always_ff @(posedge clk) begin
    if (wr_en) store[wptr[PW-1:0]] <= {wr_nb, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rd_en) {rd_nb, rd_data} <= store[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) wptr <= '0;
    else if (wr_en) wptr <= wptr + 1'b1;
  end

  assign wr_cnt = wptr;

  // R8
  buf_room_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wptr) < WORDS));
endmodule

// File: rtl/txd_byte_drain.sv
module txd_byte_drain
  import txd_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int PW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [PW:0]   cnt,
  output logic          done,
  output logic          rd_en,
  output logic [PW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  input  logic [1:0]    rd_nb,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready
);
  drn_st_t     st;
  logic [PW:0] idx;
  logic [PW:0] cnt_q;
  logic [1:0]  lane;
  logic [1:0]  nb;
  logic [31:0] sh;
  logic        final_w;

  assign rd_en   = (st == D_LD);
  assign rd_addr = idx[PW-1:0];
  assign final_w = ((idx + 1'b1) == cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= D_IDLE; idx <= '0; cnt_q <= '0; lane <= '0; nb <= '0; sh <= '0;
      tx_valid <= 1'b0; tx_data <= '0; tx_last <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        D_IDLE: if (go) begin
          idx <= '0;
          cnt_q <= cnt;
          if (cnt == '0) done <= 1'b1;
          else st <= D_LD;
        end
        D_LD: st <= D_CAP;
        D_CAP: begin
          sh       <= rd_data;
          nb       <= rd_nb;
          lane     <= '0;
          tx_valid <= 1'b1;
          tx_data  <= rd_data[7:0];
          tx_last  <= final_w && (rd_nb == 2'd0);
          st       <= D_OUT;
        end
        D_OUT: if (tx_ready) begin
          if (lane == nb) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            if (final_w) begin
              done <= 1'b1;
              st   <= D_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st  <= D_LD;
            end
          end else begin
            lane    <= lane + 2'd1;
            tx_data <= sh[{lane + 2'd1, 3'b000} +: 8];
            tx_last <= final_w && ((lane + 2'd1) == nb);
          end
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: rtl/txd_chain_dma.sv
module txd_chain_dma
  import txd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CNT_W     = 11,
  parameter int BUF_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          start,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_base,
  output logic [AW-1:0] cur_desc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready
);
  localparam int PW = $clog2(BUF_WORDS);

  dma_st_t          st;
  logic [AW-1:0]    cur, bptr, nxt_q;
  logic [1:0]       k;
  logic [30:0]      stat_q;
  logic             last_q;
  logic [CNT_W-1:0] rem, take, rem_n;

  logic          fb_wr, fb_rd, drn_done, drn_go;
  logic [PW:0]   fb_cnt;
  logic [PW-1:0] fb_raddr;
  logic [31:0]   fb_rdata;
  logic [1:0]    fb_rnb;

  assign take  = (rem > CNT_W'(4)) ? CNT_W'(4) : rem;
  assign rem_n = rem - take;

  assign cur_desc  = cur;
  assign mem_req   = (st == S_DREQ) || (st == S_BREQ) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = {1'b0, stat_q};
  always_comb begin
    case (st)
      S_BREQ:  mem_addr = bptr;
      S_DREQ:  mem_addr = cur + {{(AW-4){1'b0}}, k, 2'b00};
      default: mem_addr = cur;
    endcase
  end

  assign fb_wr  = (st == S_BWAIT) && mem_rvalid;
  assign drn_go = (st == S_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cur <= '0; bptr <= '0; nxt_q <= '0; k <= '0;
      stat_q <= '0; last_q <= 1'b0; rem <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_load) cur <= cfg_base;
          else if (start && dma_en) begin
            k  <= '0;
            st <= S_DREQ;
          end
        end
        S_DREQ: if (mem_gnt) st <= S_DWAIT;
        S_DWAIT: if (mem_rvalid) begin
          case (k)
            2'd0: stat_q <= mem_rdata[30:0];
            2'd1: begin
              last_q <= mem_rdata[LAST_BIT];
              rem    <= mem_rdata[CNT_W-1:0];
            end
            2'd2: bptr  <= mem_rdata[AW-1:0];
            default: nxt_q <= mem_rdata[AW-1:0];
          endcase
          k <= k + 2'd1;
          if (k == 2'd0 && !mem_rdata[OWN_BIT]) st <= S_IDLE;
          else if (k == 2'd3) begin
            if (rem != '0) st <= S_BREQ;
            else st <= last_q ? S_GO : S_WB;
          end else st <= S_DREQ;
        end
        S_BREQ: if (mem_gnt) st <= S_BWAIT;
        S_BWAIT: if (mem_rvalid) begin
          rem  <= rem_n;
          bptr <= bptr + AW'(4);
          if (rem_n != '0) st <= S_BREQ;
          else st <= last_q ? S_GO : S_WB;
        end
        S_GO:   st <= S_SEND;
        S_SEND: if (drn_done) st <= S_WB;
        S_WB: if (mem_gnt) begin
          cur <= nxt_q;
          k   <= '0;
          st  <= dma_en ? S_DREQ : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  txd_frame_buf #(.WORDS(BUF_WORDS)) i_fbuf (
    .clk(clk), .rst(rst), .clr(drn_done),
    .wr_en(fb_wr), .wr_data(mem_rdata), .wr_nb(take[1:0] - 2'd1),
    .wr_cnt(fb_cnt),
    .rd_en(fb_rd), .rd_addr(fb_raddr), .rd_data(fb_rdata), .rd_nb(fb_rnb)
  );

  txd_byte_drain #(.WORDS(BUF_WORDS)) i_drain (
    .clk(clk), .rst(rst), .go(drn_go), .cnt(fb_cnt), .done(drn_done),
    .rd_en(fb_rd), .rd_addr(fb_raddr), .rd_data(fb_rdata), .rd_nb(fb_rnb),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R8
  sf_order_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (st == S_SEND));
  // R9
  wb_after_send_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !tx_valid);
  // R2
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) && cfg_load |=> cur_desc == $past(cfg_base));
  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) && !dma_en |=> !mem_req);
  // R4
  park_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DWAIT) && mem_rvalid && (k == 2'd0) && !mem_rdata[OWN_BIT] |=> !mem_req);
endmodule

// File: tb/test_txd_chain_dma.sv
module test_txd_chain_dma;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, dma_en, start, cfg_load;
  logic [AW-1:0] cfg_base, cur_desc, mem_addr;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_last, tx_ready;
  logic [7:0] tx_data;

  txd_chain_dma #(.AW(AW), .CNT_W(11), .BUF_WORDS(16)) i_txd_chain_dma (
    .clk(clk), .rst(rst), .dma_en(dma_en), .start(start), .cfg_load(cfg_load),
    .cfg_base(cfg_base), .cur_desc(cur_desc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  logic [31:0] mem [0:255];
  int total = 0, bad = 0;
  int rd_cnt = 0, sent_cnt = 0;
  int rd_exp = 0, sent_exp = 0, pend_bytes = 0;
  int rd_log[$];
  logic [8:0] exp_q[$];
  int wb_addr_q[$], wb_sent_q[$];
  logic [31:0] wb_val_q[$];
  int frm_rd_q[$];
  bit new_frame = 1'b1;
  int ready_mode = 0, gnt_mode = 0;
  bit pend = 1'b0;
  logic [31:0] pend_data;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: grant decided per cycle, read data one cycle after grant
  initial begin
    int mc = 0;
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mc++;
      mem_rvalid = pend;
      mem_rdata  = pend ? pend_data : 32'h0;
      pend = 1'b0;
      mem_gnt = (gnt_mode == 0) ? 1'b1 : ((mc % 3) != 0);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          check(wb_addr_q.size() > 0, "R9", "unexpected write", mem_addr, 0);
          if (wb_addr_q.size() > 0) begin
            int a, s;
            logic [31:0] v;
            a = wb_addr_q.pop_front(); s = wb_sent_q.pop_front(); v = wb_val_q.pop_front();
            check(mem_addr == a, "R10", "writeback address", mem_addr, a);
            check(mem_wdata == v, "R9", "status value", mem_wdata, v);
            check(sent_cnt == s, "R9", "bytes sent at writeback", sent_cnt, s);
          end
          mem[mem_addr[9:2]] = mem_wdata;
        end else begin
          pend = 1'b1;
          pend_data = mem[mem_addr[9:2]];
          rd_cnt++;
          rd_log.push_back(int'(mem_addr));
        end
      end
    end
  end

  // stream sink and byte comparison
  initial begin
    int sc = 0;
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      sc++;
      tx_ready = (ready_mode == 0) ? 1'b1 : ((sc % 4) != 1);
      if (tx_valid && tx_ready) begin
        if (new_frame) begin
          check(frm_rd_q.size() > 0, "R8", "unexpected frame", 0, 1);
          if (frm_rd_q.size() > 0) begin
            int e;
            e = frm_rd_q.pop_front();
            check(rd_cnt == e, "R8", "reads done before first byte", rd_cnt, e);
          end
        end
        check(exp_q.size() > 0, "R6", "unexpected byte", tx_data, 0);
        if (exp_q.size() > 0) begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check(tx_data == e[7:0], "R6", "byte value", tx_data, e[7:0]);
          check(tx_last == e[8], "R7", "last flag", tx_last, e[8]);
        end
        sent_cnt++;
        new_frame = tx_last;
      end
    end
  end

  task automatic plan_desc(int a, int len, bit last, int nxt, int bufa, logic [7:0] seed,
                           logic [30:0] extra);
    mem[a >> 2]       = {1'b1, extra};
    mem[(a >> 2) + 1] = {1'b0, last, (pend_bytes == 0), 4'b0, 1'b1, 13'b0, 11'(len)};
    mem[(a >> 2) + 2] = bufa;
    mem[(a >> 2) + 3] = nxt;
    for (int j = 0; j < len; j++) begin
      logic [7:0] b;
      b = seed + 8'(j * 7);
      mem[(bufa >> 2) + j / 4][8 * (j % 4) +: 8] = b;
      exp_q.push_back({last && (j == len - 1), b});
    end
    rd_exp += 4 + (len + 3) / 4;
    pend_bytes += len;
    if (last) begin
      sent_exp += pend_bytes;
      pend_bytes = 0;
      frm_rd_q.push_back(rd_exp);
    end
    wb_addr_q.push_back(a);
    wb_sent_q.push_back(sent_exp);
    wb_val_q.push_back({1'b0, extra});
  endtask

  task automatic park(int a, int nxt);
    mem[a >> 2]       = 32'h0000_0011;
    mem[(a >> 2) + 1] = 32'h0;
    mem[(a >> 2) + 2] = 32'h0;
    mem[(a >> 2) + 3] = nxt;
  endtask

  task automatic fresh();
    rd_cnt = 0; rd_exp = 0; rd_log.delete();
  endtask

  task automatic load_base(int a);
    cfg_base = a; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 5000; i++) begin
      if (exp_q.size() == 0 && wb_addr_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6", "bytes left unsent", exp_q.size(), 0);
    check(wb_addr_q.size() == 0, "R9", "writebacks missing", wb_addr_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst = 1'b1; dma_en = 1'b0; start = 1'b0; cfg_load = 1'b0; cfg_base = '0;
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    check(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
    check(cur_desc == '0, "R1", "cur_desc in reset", cur_desc, 0);
    rst = 1'b0;
    @(negedge clk);

    load_base(32'h40);
    check(cur_desc == 32'h40, "R2", "pointer after load", cur_desc, 32'h40);

    // start with enable low
    mem[32'h40 >> 2] = 32'h8000_0000;
    kick();
    repeat (20) @(negedge clk);
    check(rd_cnt == 0, "R5", "reads with enable low", rd_cnt, 0);
    check(cur_desc == 32'h40, "R5", "pointer with enable low", cur_desc, 32'h40);
    mem[32'h40 >> 2] = 32'h0;

    // looped chain with a two-fragment frame, stalls on both sides
    gnt_mode = 1; ready_mode = 1; fresh();
    load_base(32'h00);
    plan_desc(32'h00, 7, 1'b1, 32'h10, 32'h200, 8'h10, 31'h0A5);
    plan_desc(32'h10, 3, 1'b0, 32'h20, 32'h240, 8'h40, 31'h003);
    plan_desc(32'h20, 6, 1'b1, 32'h30, 32'h280, 8'h80, 31'h100);
    park(32'h30, 32'h00);
    dma_en = 1'b1;
    kick();
    settle();
    check(rd_log.size() >= 4, "R3", "descriptor reads", rd_log.size(), 4);
    for (int i = 0; i < 4; i++)
      if (rd_log.size() > i)
        check(rd_log[i] == 4 * i, "R3", "descriptor word address", rd_log[i], 4 * i);
    check(cur_desc == 32'h30, "R4", "parked pointer", cur_desc, 32'h30);
    check(mem[32'h30 >> 2] == 32'h11, "R4", "unowned status untouched", mem[32'h30 >> 2], 32'h11);
    check(frm_rd_q.size() == 0, "R7", "frames not delivered", frm_rd_q.size(), 0);
    r = rd_cnt;
    repeat (30) @(negedge clk);
    check(rd_cnt == r, "R4", "reads while parked", rd_cnt, r);

    // hand the parked descriptor over, restart; ring wraps to written-back head
    fresh();
    plan_desc(32'h30, 4, 1'b1, 32'h00, 32'h2C0, 8'h21, 31'h0);
    kick();
    settle();
    check(rd_log.size() > 0 && rd_log[0] == 32'h30, "R3", "resume address",
          rd_log.size() > 0 ? rd_log[0] : -1, 32'h30);
    check(cur_desc == 32'h00, "R10", "pointer after wrap", cur_desc, 32'h00);

    // second chain, no stalls, three-fragment frame
    gnt_mode = 0; ready_mode = 0; fresh();
    load_base(32'h80);
    check(cur_desc == 32'h80, "R2", "pointer after reload", cur_desc, 32'h80);
    plan_desc(32'h80, 1, 1'b1, 32'h90, 32'h300, 8'h5A, 31'h0);
    plan_desc(32'h90, 2, 1'b0, 32'hA0, 32'h340, 8'h61, 31'h7);
    plan_desc(32'hA0, 5, 1'b0, 32'hB0, 32'h380, 8'h72, 31'h0);
    plan_desc(32'hB0, 9, 1'b1, 32'hC0, 32'h3C0, 8'hE3, 31'h0);
    park(32'hC0, 32'h80);
    kick();
    settle();
    check(cur_desc == 32'hC0, "R10", "pointer after second chain", cur_desc, 32'hC0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule